// File: doc/BRIEF.md
# UART In-Band XON/XOFF Flow Controller

This block sits between a UART's receive FIFO, its transmit FIFO and its serializer, and adds in-band software flow control. On the receive side it compares the receive FIFO fill level with two programmable thresholds. When the level climbs to the high mark it asks the serializer to insert the stop token. Once reads have drained the level to the low mark it asks for the resume token. A separate threshold drives a receive-level interrupt.

On the transmit side it inspects each decoded received character. A stop token halts the pulling of data characters from the transmit FIFO, and a resume token lets them flow again. Tokens are consumed here and never reach the receive FIFO. A character that the serializer has already started is allowed to finish. Token insertion always wins over the next data character.

Each threshold is a 4-bit register field scaled by 8. A field value of 7 therefore means a level of 56 characters. Serialization, the FIFOs and baud generation belong to neighbouring blocks.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: With flow control enabled and no stop token outstanding, when `rx_level` >= 8 * `cfg_stop_fld` and `tx_boundary` is 1, `ins_req` is 1 in that same cycle and `ins_char` equals `tok_stop`.
- R2: After a stop token has been inserted (an `ins_req` cycle carrying `tok_stop`), no further stop token is requested while the level stays at or above the high mark.
- R3: After a stop token has been inserted, when `rx_level` <= 8 * `cfg_go_fld` and `tx_boundary` is 1, `ins_req` is 1 with `ins_char` equal to `tok_go`. Inserting it re-arms the stop request.
- R4: A received character equal to `tok_stop` (with `rx_valid` 1 and flow control enabled) sets `tx_halt` from the next cycle on. While `tx_halt` is 1, `tx_data_take` stays 0.
- R5: A received character equal to `tok_go` (and not equal to `tok_stop`) clears `tx_halt` from the next cycle on. Data characters are then taken again.
- R6: A received token character is not forwarded, so `rx_push` is 0 in its cycle. Any other valid character gives `rx_push` equal to 1 in the same cycle.
- R7: `rx_err_mark` is 1 in every cycle in which `rx_valid` and `rx_perr` are both 1, token characters included.
- R8: In a cycle with `ins_req` equal to 1, `tx_data_take` is 0.
- R9: `ins_req` and `tx_data_take` are only ever 1 when `tx_boundary` is 1.
- R10: `irq_rx` is 1 exactly when `rx_level` >= 8 * `cfg_irq_fld`.
- R11: When `fc_en` is 0, and after reset, `tx_halt` is 0 and no token is outstanding. With `fc_en` 0, `ins_req` stays 0 and token characters are pushed like data.
- R12: Token insertion is not blocked by `tx_halt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_en | input | 1 | Software flow control enable |
| cfg_stop_fld | input | 4 | High-mark field; threshold is this value times 8 |
| cfg_go_fld | input | 4 | Low-mark field; threshold is this value times 8 |
| cfg_irq_fld | input | 4 | Receive interrupt field; threshold is this value times 8 |
| tok_stop | input | CHAR_W | Stop token character |
| tok_go | input | CHAR_W | Resume token character |
| rx_level | input | LEVEL_W | Receive FIFO fill level |
| rx_valid | input | 1 | A decoded received character is present |
| rx_char | input | CHAR_W | Decoded received character |
| rx_perr | input | 1 | Parity error on the received character |
| rx_push | output | 1 | Write the received character into the receive FIFO |
| rx_err_mark | output | 1 | Mark an error entry in the receive FIFO |
| tx_boundary | input | 1 | Serializer is between characters and can load one |
| tx_data_avail | input | 1 | Transmit FIFO holds a data character |
| ins_req | output | 1 | Load `ins_char` into the serializer now |
| ins_char | output | CHAR_W | Token character to insert |
| tx_data_take | output | 1 | Pop and load the next data character now |
| tx_halt | output | 1 | Data transmission paused by a received stop token |
| irq_rx | output | 1 | Receive level interrupt |

## Verification
Several rules are checked by the assertions on every cycle: token priority over data, loads only at character boundaries, a quiet transmit path while halted, tokens being swallowed rather than pushed, and the reaction to received stop and resume tokens. The hysteresis needs the bench's scenarios to show it. Those scenarios check that one crossing of the high mark yields one stop token, that the resume token waits for the low mark, and that disabling or resetting the block drops a halt. The threshold scaling of the interrupt is also covered by the scenarios.

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl #(
  parameter int LEVEL_W  = 7,
  parameter int CHAR_W   = 8,
  parameter int FLD_W    = 4,
  parameter int SCALE_SH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_en,
  input  logic [FLD_W-1:0]  cfg_stop_fld,
  input  logic [FLD_W-1:0]  cfg_go_fld,
  input  logic [FLD_W-1:0]  cfg_irq_fld,
  input  logic [CHAR_W-1:0] tok_stop,
  input  logic [CHAR_W-1:0] tok_go,
  input  logic [LEVEL_W-1:0] rx_level,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_perr,
  output logic              rx_push,
  output logic              rx_err_mark,
  input  logic              tx_boundary,
  input  logic              tx_data_avail,
  output logic              ins_req,
  output logic [CHAR_W-1:0] ins_char,
  output logic              tx_data_take,
  output logic              tx_halt,
  output logic              irq_rx
);

  localparam int THR_W = FLD_W + SCALE_SH;

  function automatic logic [LEVEL_W-1:0] scale(input logic [FLD_W-1:0] f);
    logic [THR_W-1:0] t;
    t = {f, {SCALE_SH{1'b0}}};
    return LEVEL_W'(t);
  endfunction

  logic stop_sent_q;
  logic halt_q;

  wire [LEVEL_W-1:0] stop_thr = scale(cfg_stop_fld);
  wire [LEVEL_W-1:0] go_thr   = scale(cfg_go_fld);
  wire [LEVEL_W-1:0] irq_thr  = scale(cfg_irq_fld);

  wire hit_stop  = rx_valid && fc_en && (rx_char == tok_stop);
  wire hit_go    = rx_valid && fc_en && (rx_char == tok_go);

  wire need_stop = fc_en && !stop_sent_q && (rx_level >= stop_thr);
  wire need_go   = fc_en &&  stop_sent_q && (rx_level <= go_thr);

  assign ins_req      = tx_boundary && (need_stop || need_go);
  assign ins_char     = need_stop ? tok_stop : tok_go;
  assign tx_data_take = tx_boundary && tx_data_avail && !ins_req && !halt_q;
  assign tx_halt      = halt_q;

  assign rx_push      = rx_valid && !hit_stop && !hit_go;
  assign rx_err_mark  = rx_valid && rx_perr;
  assign irq_rx       = rx_level >= irq_thr;

  always_ff @(posedge clk) begin
    if (!rst_n || !fc_en) begin
      stop_sent_q <= 1'b0;
      halt_q      <= 1'b0;
    end else begin
      if (ins_req) stop_sent_q <= need_stop;
      if (hit_stop)    halt_q <= 1'b1;
      else if (hit_go) halt_q <= 1'b0;
    end
  end

endmodule

// File: rtl/xonxoff_flow_chk.sv
module xonxoff_flow_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fc_en,
  input logic [CHAR_W-1:0] tok_stop,
  input logic [CHAR_W-1:0] tok_go,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_char,
  input logic              rx_perr,
  input logic              rx_push,
  input logic              rx_err_mark,
  input logic              tx_boundary,
  input logic              ins_req,
  input logic              tx_data_take,
  input logic              tx_halt
);

  a_r8_token_beats_data: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req |-> !tx_data_take);

  a_r9_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req || tx_data_take) |-> tx_boundary);

  a_r4_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fc_en && rx_char == tok_stop) |=> tx_halt);

  a_r4_no_data_halted: assert property (@(posedge clk) disable iff (!rst_n)
    tx_halt |-> !tx_data_take);

  a_r5_go_resumes: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fc_en && rx_char == tok_go && rx_char != tok_stop) |=> !tx_halt);

  a_r6_token_swallowed: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fc_en && (rx_char == tok_stop || rx_char == tok_go)) |-> !rx_push);

  a_r7_perr_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_perr) |-> rx_err_mark);

  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |-> !ins_req);

  a_r11_disable_clears_halt: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> !tx_halt);

endmodule

bind xonxoff_flow_ctrl xonxoff_flow_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .tok_stop(tok_stop), .tok_go(tok_go),
  .rx_valid(rx_valid), .rx_char(rx_char), .rx_perr(rx_perr), .rx_push(rx_push),
  .rx_err_mark(rx_err_mark), .tx_boundary(tx_boundary), .ins_req(ins_req),
  .tx_data_take(tx_data_take), .tx_halt(tx_halt)
);

// File: tb/xonxoff_flow_ctrl_bench.sv
`timescale 1ns/1ps
module xonxoff_flow_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n, fc_en;
  logic [3:0] cfg_stop_fld, cfg_go_fld, cfg_irq_fld;
  logic [7:0] tok_stop, tok_go, rx_char, ins_char;
  logic [6:0] rx_level;
  logic rx_valid, rx_perr, rx_push, rx_err_mark;
  logic tx_boundary, tx_data_avail, ins_req, tx_data_take, tx_halt, irq_rx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xonxoff_flow_ctrl u_xonxoff_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en),
    .cfg_stop_fld(cfg_stop_fld), .cfg_go_fld(cfg_go_fld), .cfg_irq_fld(cfg_irq_fld),
    .tok_stop(tok_stop), .tok_go(tok_go), .rx_level(rx_level),
    .rx_valid(rx_valid), .rx_char(rx_char), .rx_perr(rx_perr),
    .rx_push(rx_push), .rx_err_mark(rx_err_mark),
    .tx_boundary(tx_boundary), .tx_data_avail(tx_data_avail),
    .ins_req(ins_req), .ins_char(ins_char), .tx_data_take(tx_data_take),
    .tx_halt(tx_halt), .irq_rx(irq_rx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // {irq_fld, level, valid, char, perr, exp_irq, exp_push, exp_err}
  localparam int NV = 8;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {4'd6,  7'd47,  1'b0, 8'h00, 1'b0, 3'b000},
    {4'd6,  7'd48,  1'b1, 8'h41, 1'b0, 3'b110},
    {4'd6,  7'd49,  1'b1, 8'h0F, 1'b0, 3'b100},
    {4'd2,  7'd15,  1'b1, 8'h0D, 1'b1, 3'b001},
    {4'd2,  7'd16,  1'b1, 8'h42, 1'b1, 3'b111},
    {4'd0,  7'd0,   1'b0, 8'h00, 1'b0, 3'b100},
    {4'd15, 7'd119, 1'b1, 8'h55, 1'b0, 3'b010},
    {4'd15, 7'd120, 1'b0, 8'h00, 1'b0, 3'b100}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fc_en = 1'b1;
    cfg_stop_fld = 4'd7; cfg_go_fld = 4'd4; cfg_irq_fld = 4'd6;
    tok_stop = 8'h0F; tok_go = 8'h0D;
    rx_level = '0; rx_valid = 1'b0; rx_char = '0; rx_perr = 1'b0;
    tx_boundary = 1'b0; tx_data_avail = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();

    // R11: reset state
    chk("R11 reset halt", int'(tx_halt), 0);
    chk("R10 irq at level 0", int'(irq_rx), 0);

    // Table: interrupt scaling, push and error marking (R6, R7, R10)
    for (int i = 0; i < NV; i++) begin
      cfg_irq_fld = VEC[i][23:20];
      rx_level    = VEC[i][19:13];
      rx_valid    = VEC[i][12];
      rx_char     = VEC[i][11:4];
      rx_perr     = VEC[i][3];
      #1;
      chk("R10 irq table",  int'(irq_rx),      int'(VEC[i][2]));
      chk("R6 push table",  int'(rx_push),     int'(VEC[i][1]));
      chk("R7 err table",   int'(rx_err_mark), int'(VEC[i][0]));
      step();
    end
    rx_valid = 1'b0; rx_perr = 1'b0; cfg_irq_fld = 4'd6;

    rst_n = 1'b0; step(); rst_n = 1'b1; step();

    // R1 below and at the high mark
    tx_boundary = 1'b1; tx_data_avail = 1'b1; rx_level = 7'd55; #1;
    chk("R1 no req at 55", int'(ins_req), 0);
    chk("R9 data taken", int'(tx_data_take), 1);
    rx_level = 7'd56; #1;
    chk("R1 req at 56", int'(ins_req), 1);
    chk("R1 stop char", int'(ins_char), 8'h0F);
    chk("R8 data held back", int'(tx_data_take), 0);
    step();
    rx_level = 7'd57; #1;
    chk("R2 single stop", int'(ins_req), 0);
    chk("R2 data resumes", int'(tx_data_take), 1);

    // R3 low mark with boundary gating (R9)
    rx_level = 7'd33; #1;
    chk("R3 no go above low mark", int'(ins_req), 0);
    tx_boundary = 1'b0; rx_level = 7'd32; #1;
    chk("R9 no req off boundary", int'(ins_req), 0);
    chk("R9 no take off boundary", int'(tx_data_take), 0);
    tx_boundary = 1'b1; #1;
    chk("R3 go req", int'(ins_req), 1);
    chk("R3 go char", int'(ins_char), 8'h0D);
    step();
    chk("R3 go sent once", int'(ins_req), 0);

    // R4 received stop token halts data
    rx_valid = 1'b1; rx_char = 8'h0F; #1;
    chk("R6 stop token swallowed", int'(rx_push), 0);
    step();
    rx_valid = 1'b0; #1;
    chk("R4 halted", int'(tx_halt), 1);
    chk("R4 no data while halted", int'(tx_data_take), 0);

    // R12 token insertion during halt
    rx_level = 7'd56; #1;
    chk("R12 stop req while halted", int'(ins_req), 1);
    step();

    // R5 received go token resumes
    rx_level = 7'd50;
    rx_valid = 1'b1; rx_char = 8'h0D; #1;
    chk("R6 go token swallowed", int'(rx_push), 0);
    step();
    rx_valid = 1'b0; #1;
    chk("R5 resumed", int'(tx_halt), 0);
    chk("R5 data flows", int'(tx_data_take), 1);

    // R11 disable clears halt and stops tokens
    rx_valid = 1'b1; rx_char = 8'h0F; step(); rx_valid = 1'b0; #1;
    chk("R4 halted again", int'(tx_halt), 1);
    fc_en = 1'b0; step();
    rx_level = 7'd60; #1;
    chk("R11 disable clears halt", int'(tx_halt), 0);
    chk("R11 no req when disabled", int'(ins_req), 0);
    rx_valid = 1'b1; rx_char = 8'h0F; #1;
    chk("R11 token pushed when disabled", int'(rx_push), 1);
    step(); rx_valid = 1'b0;

    // R11 reset mid-halt
    fc_en = 1'b1; rx_level = 7'd0;
    rx_valid = 1'b1; rx_char = 8'h0F; step(); rx_valid = 1'b0; #1;
    chk("R4 halted before reset", int'(tx_halt), 1);
    rst_n = 1'b0; step(); rst_n = 1'b1; #1;
    chk("R11 reset clears halt", int'(tx_halt), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule